// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator with Dead-Time

This block produces the switch drive for a multiphase buck converter from one system clock. Every phase has a high-side pulse output and a low-side drive output. A shared period counter sets the switching period. The phases in use start their periods at evenly spaced points within that period. Each phase takes its own on-time command. A common maximum on-time clamps that command, and two independent dead-time delays separate the high-side and low-side conduction windows.

A control loop outside the block writes the on-time commands. The block latches a phase's command only when that phase's period begins. The output enable and the soft-start completion input together gate all drive: when either is low, every output goes low in the same cycle and the timing state is cleared. When both rise again, phase 0 starts a fresh period at the first clock edge.

In a period, each active phase goes through these steps: release the low side, wait the low-to-high dead-time, drive the high side for the effective on-time, wait the high-to-low dead-time, then hold the low side on until its next period begins. Configurations are expected to satisfy dead-time rise + effective on-time + dead-time fall < period.

Top module: `pwm_multiphase`

## Requirements
- R1: With both enables high, each active phase begins a new period every `periodCycles` clock cycles. The period value is captured at the wrap of the shared counter.
- R2: The number of phases in use, N, is `phasesInUse`. A value of 0 counts as 1, and values above 6 count as 6. Phase i (i < N) starts its period floor(i*periodCycles/N) cycles after phase 0. Phases with i >= N keep both outputs low.
- R3: The high-side pulse of a phase lasts min(on-time command, `maxOnCycles`) cycles. The command for phase i sits at bits [i*CNT_W +: CNT_W] of `onTimeCmd`.
- R4: The block samples the on-time command only on the clock edge that starts that phase's period. A change made later in the period affects only the next pulse.
- R5: While `outEnable` or `softStartDone` is low, every `pwmHigh` and `driveLow` bit is low in that same cycle.
- R6: For any phase, `pwmHigh` and `driveLow` are never high together.
- R7: Between the low side turning off and the high side turning on, both outputs stay low for exactly `deadLoToHi` cycles.
- R8: After the high side turns off, both outputs stay low for exactly `deadHiToLo` cycles. The low side then stays on until the phase's next period starts.
- R9: A phase whose effective on-time is zero never drives the high side. It keeps the low side on for the whole period.
- R10: A phase whose `phaseEnable` bit is 0 keeps both outputs low.
- R11: The first clock edge with both enables high starts phase 0's period. Before its first period start, a phase keeps both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| outEnable | input | 1 | Global drive enable |
| softStartDone | input | 1 | Soft-start complete; low holds all drive off |
| periodCycles | input | CNT_W | Switching period in clock cycles |
| phasesInUse | input | 3 | Number of interleaved phases N |
| phaseEnable | input | 6 | Per-phase switching enable |
| onTimeCmd | input | 6*CNT_W | Per-phase high-side on-time commands |
| maxOnCycles | input | CNT_W | Maximum high-side on-time |
| deadLoToHi | input | DT_W | Dead-time from low-side off to high-side on |
| deadHiToLo | input | DT_W | Dead-time from high-side off to low-side on |
| pwmHigh | output | 6 | High-side PWM per phase |
| driveLow | output | 6 | Low-side drive per phase |

## Verification
Two operations can land on the same clock edge: a phase's period start, which captures the on-time command, and the duty clamp, which limits the captured value. The bench changes one phase's command in the cycle just before that phase's period start. The new value is above the maximum on-time. The following pulse must have the clamped width. The pulse already in progress must keep the width it started with.

// File: rtl/pwm_mp_pkg.sv
package pwm_mp_pkg;

  localparam int unsigned MP_PHASES = 6;
  localparam int unsigned MP_PC_W   = $clog2(MP_PHASES + 1);

  typedef enum logic [2:0] {
    LANE_IDLE = 3'd0,
    LANE_RISE = 3'd1,
    LANE_HIGH = 3'd2,
    LANE_FALL = 3'd3,
    LANE_LOW  = 3'd4
  } laneState_e;

  // strobes from the timebase (control) to the lanes (datapath)
  typedef struct packed {
    logic                 run;
    logic [MP_PHASES-1:0] start;
    logic [MP_PHASES-1:0] active;
  } ctrlStrobes_t;

endpackage

// File: rtl/pwm_mp_timebase.sv
module pwm_mp_timebase
  import pwm_mp_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runReq,
  input  logic [CNT_W-1:0]     periodCfg,
  input  logic [MP_PC_W-1:0]   phaseCountCfg,
  input  logic [MP_PHASES-1:0] phaseEnable,
  output ctrlStrobes_t         strobes
);

  localparam int unsigned PROD_W = CNT_W + MP_PC_W;

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   perLat;
  logic [MP_PC_W-1:0] numLat;
  logic               wrap;

  function automatic logic [MP_PC_W-1:0] clampCount(input logic [MP_PC_W-1:0] c);
    if (c == '0)
      return MP_PC_W'(1);
    else if (c > MP_PC_W'(MP_PHASES))
      return MP_PC_W'(MP_PHASES);
    else
      return c;
  endfunction

  assign wrap = (cnt >= perLat - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      perLat <= '0;
      numLat <= MP_PC_W'(1);
    end else if (!runReq || wrap) begin
      cnt    <= '0;
      perLat <= periodCfg;
      numLat <= clampCount(phaseCountCfg);
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign strobes.run = runReq;

  for (genvar i = 0; i < MP_PHASES; i++) begin : g_offset
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    assign prod = PROD_W'(i) * PROD_W'(perLat);
    assign quot = prod / PROD_W'(numLat);
    assign strobes.active[i] = phaseEnable[i] && (MP_PC_W'(i) < numLat);
    assign strobes.start[i]  = runReq && strobes.active[i] && (cnt == quot[CNT_W-1:0]);
  end

endmodule

// File: rtl/pwm_mp_lane.sv
module pwm_mp_lane
  import pwm_mp_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             start,
  input  logic             active,
  input  logic [CNT_W-1:0] onCmd,
  input  logic [CNT_W-1:0] maxOn,
  input  logic [DT_W-1:0]  deadRise,
  input  logic [DT_W-1:0]  deadFall,
  output logic             hi,
  output logic             lo
);

  laneState_e       st;
  logic [CNT_W-1:0] tmr;
  logic [CNT_W-1:0] onLat;
  logic [CNT_W-1:0] onEff;

  // duty clamp applied to the command captured at the period start
  assign onEff = (onCmd < maxOn) ? onCmd : maxOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= LANE_IDLE;
      tmr   <= '0;
      onLat <= '0;
    end else if (!run || !active) begin
      st  <= LANE_IDLE;
      tmr <= '0;
    end else begin
      unique case (st)
        LANE_IDLE, LANE_LOW: begin
          if (start) begin
            onLat <= onEff;
            if (onEff == '0) begin
              st <= LANE_LOW;
            end else if (deadRise == '0) begin
              st  <= LANE_HIGH;
              tmr <= onEff - CNT_W'(1);
            end else begin
              st  <= LANE_RISE;
              tmr <= CNT_W'(deadRise) - CNT_W'(1);
            end
          end
        end
        LANE_RISE: begin
          if (tmr == '0) begin
            st  <= LANE_HIGH;
            tmr <= onLat - CNT_W'(1);
          end else begin
            tmr <= tmr - CNT_W'(1);
          end
        end
        LANE_HIGH: begin
          if (tmr == '0) begin
            if (deadFall == '0) begin
              st <= LANE_LOW;
            end else begin
              st  <= LANE_FALL;
              tmr <= CNT_W'(deadFall) - CNT_W'(1);
            end
          end else begin
            tmr <= tmr - CNT_W'(1);
          end
        end
        LANE_FALL: begin
          if (tmr == '0) st <= LANE_LOW;
          else           tmr <= tmr - CNT_W'(1);
        end
        default: st <= LANE_IDLE;
      endcase
    end
  end

  assign hi = run && active && (st == LANE_HIGH);
  assign lo = run && active && (st == LANE_LOW);

endmodule

// File: rtl/pwm_mp_lanes.sv
module pwm_mp_lanes
  import pwm_mp_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [MP_PHASES*CNT_W-1:0] onTimeFlat,
  input  logic [CNT_W-1:0]           maxOn,
  input  logic [DT_W-1:0]            deadRise,
  input  logic [DT_W-1:0]            deadFall,
  output logic [MP_PHASES-1:0]       hiOut,
  output logic [MP_PHASES-1:0]       loOut
);

  for (genvar i = 0; i < MP_PHASES; i++) begin : g_lane
    pwm_mp_lane #(
      .CNT_W(CNT_W),
      .DT_W (DT_W)
    ) u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .run     (strobes.run),
      .start   (strobes.start[i]),
      .active  (strobes.active[i]),
      .onCmd   (onTimeFlat[i*CNT_W +: CNT_W]),
      .maxOn   (maxOn),
      .deadRise(deadRise),
      .deadFall(deadFall),
      .hi      (hiOut[i]),
      .lo      (loOut[i])
    );
  end

endmodule

// File: rtl/pwm_multiphase.sv
module pwm_multiphase
  import pwm_mp_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       outEnable,
  input  logic                       softStartDone,
  input  logic [CNT_W-1:0]           periodCycles,
  input  logic [MP_PC_W-1:0]         phasesInUse,
  input  logic [MP_PHASES-1:0]       phaseEnable,
  input  logic [MP_PHASES*CNT_W-1:0] onTimeCmd,
  input  logic [CNT_W-1:0]           maxOnCycles,
  input  logic [DT_W-1:0]            deadLoToHi,
  input  logic [DT_W-1:0]            deadHiToLo,
  output logic [MP_PHASES-1:0]       pwmHigh,
  output logic [MP_PHASES-1:0]       driveLow
);

  ctrlStrobes_t strobes;

  pwm_mp_timebase #(
    .CNT_W(CNT_W)
  ) u_timebase (
    .clk          (clk),
    .rstN         (rstN),
    .runReq       (outEnable && softStartDone),
    .periodCfg    (periodCycles),
    .phaseCountCfg(phasesInUse),
    .phaseEnable  (phaseEnable),
    .strobes      (strobes)
  );

  pwm_mp_lanes #(
    .CNT_W(CNT_W),
    .DT_W (DT_W)
  ) u_lanes (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .onTimeFlat(onTimeCmd),
    .maxOn     (maxOnCycles),
    .deadRise  (deadLoToHi),
    .deadFall  (deadHiToLo),
    .hiOut     (pwmHigh),
    .loOut     (driveLow)
  );

endmodule

// File: rtl/pwm_multiphase_chk.sv
module pwm_multiphase_chk
  import pwm_mp_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 outEnable,
  input logic                 softStartDone,
  input logic [CNT_W-1:0]     maxOnCycles,
  input logic [DT_W-1:0]      deadLoToHi,
  input logic [DT_W-1:0]      deadHiToLo,
  input logic [MP_PHASES-1:0] pwmHigh,
  input logic [MP_PHASES-1:0] driveLow
);

  // R5: drive is off whenever either enable is low
  a_r5_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    !(outEnable && softStartDone) |-> (pwmHigh == '0 && driveLow == '0));

  // R6: never both switches of one phase on
  a_r6_no_shoot: assert property (@(posedge clk) disable iff (!rstN)
    (pwmHigh & driveLow) == '0);

  for (genvar i = 0; i < MP_PHASES; i++) begin : g_ph
    logic [CNT_W:0] hiLen;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           hiLen <= '0;
      else if (pwmHigh[i]) hiLen <= hiLen + 1'b1;
      else                 hiLen <= '0;
    end

    // R3: pulse never exceeds the clamp (limit held constant while switching)
    a_r3_clamp: assert property (@(posedge clk) disable iff (!rstN)
      pwmHigh[i] |-> (hiLen < {1'b0, maxOnCycles}));

    // R7: nonzero low-to-high dead-time leaves a gap before the high side
    a_r7_rise_gap: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(pwmHigh[i]) && deadLoToHi != '0 && $stable(deadLoToHi)) |-> !$past(driveLow[i]));

    // R8: nonzero high-to-low dead-time leaves a gap before the low side
    a_r8_fall_gap: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(driveLow[i]) && deadHiToLo != '0 && $stable(deadHiToLo)) |-> !$past(pwmHigh[i]));
  end

endmodule

bind pwm_multiphase pwm_multiphase_chk #(
  .CNT_W(CNT_W),
  .DT_W (DT_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .outEnable    (outEnable),
  .softStartDone(softStartDone),
  .maxOnCycles  (maxOnCycles),
  .deadLoToHi   (deadLoToHi),
  .deadHiToLo   (deadHiToLo),
  .pwmHigh      (pwmHigh),
  .driveLow     (driveLow)
);

// File: tb/test_pwm_multiphase.sv
`timescale 1ns/1ps
module test_pwm_multiphase;

  localparam int CNT_W = 12;
  localparam int DT_W  = 6;
  localparam int NPH   = 6;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   outEnable = 1'b0;
  logic                   softStartDone = 1'b0;
  logic [CNT_W-1:0]       periodCycles = '0;
  logic [2:0]             phasesInUse = '0;
  logic [NPH-1:0]         phaseEnable = '0;
  logic [NPH*CNT_W-1:0]   onTimeCmd;
  logic [CNT_W-1:0]       maxOnCycles = '0;
  logic [DT_W-1:0]        deadLoToHi = '0;
  logic [DT_W-1:0]        deadHiToLo = '0;
  logic [NPH-1:0]         pwmHigh;
  logic [NPH-1:0]         driveLow;

  int onArr [NPH];
  int latOn [NPH];

  always_comb
    for (int k = 0; k < NPH; k++) onTimeCmd[k*CNT_W +: CNT_W] = CNT_W'(onArr[k]);

  always #2 clk = ~clk;

  pwm_multiphase #(.CNT_W(CNT_W), .DT_W(DT_W)) i_pwm_multiphase (
    .clk(clk), .rstN(rstN), .outEnable(outEnable), .softStartDone(softStartDone),
    .periodCycles(periodCycles), .phasesInUse(phasesInUse), .phaseEnable(phaseEnable),
    .onTimeCmd(onTimeCmd), .maxOnCycles(maxOnCycles), .deadLoToHi(deadLoToHi),
    .deadHiToLo(deadHiToLo), .pwmHigh(pwmHigh), .driveLow(driveLow)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 0;
  logic [2*NPH-1:0] expQ [$];
  string            tagQ [$];
  int               cycQ [$];

  // monitor: pop one expected item per sample, away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [2*NPH-1:0] e;
      string t;
      int c;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      c = cycQ.pop_front();
      nChecks++;
      if ({pwmHigh, driveLow} !== e) begin
        nFails++;
        $display("FAIL %s sample %0d: hi=%b lo=%b expected hi=%b lo=%b",
                 t, c, pwmHigh, driveLow, e[2*NPH-1:NPH], e[NPH-1:0]);
      end
    end
  end

  function automatic int effCount(input int c);
    if (c == 0) return 1;
    if (c > NPH) return NPH;
    return c;
  endfunction

  // reference: expected {hi,lo} for sample after edge t of the current run
  function automatic logic [2*NPH-1:0] model(input int t);
    logic [NPH-1:0] h, l;
    int n, p, dr, df, mx;
    h = '0; l = '0;
    n  = effCount(int'(phasesInUse));
    p  = int'(periodCycles);
    dr = int'(deadLoToHi);
    df = int'(deadHiToLo);
    mx = int'(maxOnCycles);
    for (int i = 0; i < NPH; i++) begin
      int off, rel, r, o;
      if (phaseEnable[i] && i < n) begin
        off = (i * p) / n;
        rel = t - 1 - off;
        if (rel >= 0) begin
          r = rel % p;
          if (r == 0) latOn[i] = (onArr[i] < mx) ? onArr[i] : mx;
          o = latOn[i];
          if (o == 0)               l[i] = 1'b1;
          else if (r < dr)          ;
          else if (r < dr + o)      h[i] = 1'b1;
          else if (r < dr + o + df) ;
          else                      l[i] = 1'b1;
        end
      end
    end
    return {h, l};
  endfunction

  task automatic push(input logic [2*NPH-1:0] e, input string tag, input int c);
    expQ.push_back(e);
    tagQ.push_back(tag);
    cycQ.push_back(c);
  endtask

  // driver: run one configuration, optionally change one command mid-run
  task automatic runScenario(input int cycles, input string tag,
                             input int chgAt, input int chgPh, input int chgVal,
                             input bit dropSoftOnly);
    for (int k = 0; k < NPH; k++) latOn[k] = 0;
    @(posedge clk); #1;
    outEnable = 1'b1;
    softStartDone = 1'b1;
    for (int t = 1; t <= cycles; t++) begin
      @(posedge clk); #1;
      push(model(t), tag, t);
      if (t == chgAt) onArr[chgPh] = chgVal;
    end
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      if (k == 0) begin
        if (dropSoftOnly) softStartDone = 1'b0;
        else              outEnable = 1'b0;
      end
      push('0, "R5 hold-off", cycles + k + 1);
    end
    @(posedge clk); #1;
    outEnable = 1'b0;
    softStartDone = 1'b0;
    wait (expQ.size() == 0);
  endtask

  initial begin
    for (int k = 0; k < NPH; k++) onArr[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    nChecks++;
    if (pwmHigh !== '0 || driveLow !== '0) begin
      nFails++;
      $display("FAIL R11 reset: hi=%b lo=%b expected hi=0 lo=0", pwmHigh, driveLow);
    end
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    nChecks++;
    if (pwmHigh !== '0 || driveLow !== '0) begin
      nFails++;
      $display("FAIL R5 idle before enable: hi=%b lo=%b expected hi=0 lo=0", pwmHigh, driveLow);
    end

    // three interleaved phases, upper phases unused, both dead-times nonzero
    periodCycles = 60; phasesInUse = 3; phaseEnable = 6'b111111;
    onArr = '{10, 20, 15, 9, 9, 9}; maxOnCycles = 40;
    deadLoToHi = 2; deadHiToLo = 3;
    runScenario(200, "R1/R2/R6/R7/R8/R11", -1, 0, 0, 1'b0);

    // six phases, clamp, zero on-time, disabled phase, command change at start edge
    periodCycles = 48; phasesInUse = 6; phaseEnable = 6'b101111;
    onArr = '{30, 5, 45, 0, 12, 8}; maxOnCycles = 20;
    deadLoToHi = 1; deadHiToLo = 0;
    runScenario(200, "R3/R4/R9/R10", 8 + 48, 1, 25, 1'b0);

    // phase count 0 acts as one phase, zero dead-times
    periodCycles = 30; phasesInUse = 0; phaseEnable = 6'b111111;
    onArr = '{7, 7, 7, 7, 7, 7}; maxOnCycles = 29;
    deadLoToHi = 0; deadHiToLo = 0;
    runScenario(120, "R2 count-zero", -1, 0, 0, 1'b0);

    // two phases, soft-start input dropped mid-run
    periodCycles = 40; phasesInUse = 2; phaseEnable = 6'b000011;
    onArr = '{12, 9, 0, 0, 0, 0}; maxOnCycles = 30;
    deadLoToHi = 3; deadHiToLo = 2;
    runScenario(90, "R1/R7/R8 two-phase", 30, 0, 4, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule